// File: doc/BRIEF.md
# Split Instruction/Data Address Translation Cache

This block translates 26-bit virtual addresses into physical addresses through two independent set-associative caches of page translations, one serving instruction fetches and one serving data accesses. Pages are 4 KB, so the low 12 address bits pass through untouched and the upper 14 bits form the virtual page number. The instruction side holds 16 translations in 4 sets of 4 ways and evicts the least recently used way. The data side holds 32 translations in 8 sets of 4 ways and evicts a way chosen by a pseudo-random generator.

A request is accepted when `req_valid` and `req_ready` are both high. On a hit, the physical address is returned one cycle later. On a miss, the block raises a refill request carrying the page number and side, and it stalls new requests. It then waits for a refill response carrying the physical page number. It installs that translation and returns the physical address one cycle after the response. The write flag travels with the request but has no effect on translation.

Each side counts its own accepted accesses and its own hits. A synchronous flush empties both sides.

Top module: `split_tlb`

## Requirements
- R1: The returned physical address is `{physical page number, req_vaddr[11:0]}`, and the page number looked up is `req_vaddr[25:12]`.
- R2: The instruction side indexes with page-number bits [1:0] and the data side with bits [2:0], tagging with the remaining bits. An accepted request that hits drives `resp_valid`=1 and `resp_hit`=1 with the stored page number in the following cycle, for one cycle.
- R3: An accepted request that misses drives `refill_req_valid`=1 with its page number and side in the following cycle. `req_ready` stays low while the refill is outstanding. A refill response taken in that state installs the translation and yields `resp_valid`=1, `resp_hit`=0 in the next cycle.
- R4: A fill goes to the lowest-numbered invalid way of the indexed set, if the set has any invalid way.
- R5: On the instruction side, both a hit and a fill make the touched way most recently used. With no invalid way, the least recently used way is replaced. After reset or flush, way 0 is most recent and way 3 is least recent.
- R6: On the data side, with no invalid way, the victim is bit [1:0] of a 32-bit Galois LFSR. The LFSR resets to 14897. On every data-side fill it advances as: if bit 0 is set, state = (state>>1) ^ 0x80200003, otherwise state = state>>1.
- R7: Each side keeps an access counter, incremented on every accepted request of that side, and a hit counter, incremented on every accepted hit of that side. Both are visible one cycle after acceptance.
- R8: `flush` invalidates every entry, restores the LRU order, and drops any outstanding refill. It holds `req_ready` low in its cycle, and it leaves the counters unchanged.
- R9: After reset, all counters are zero, `req_ready`=1, and `resp_valid` and `refill_req_valid` are 0.
- R10: `refill_rsp_valid` asserted while no refill is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous invalidate of both sides |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | Write flag (carried, not used for translation) |
| req_instr | input | 1 | 1 selects the instruction side, 0 the data side |
| req_vaddr | input | 26 | Virtual address |
| resp_valid | output | 1 | Translation result valid |
| resp_hit | output | 1 | Result came from a hit (0 after a refill) |
| resp_paddr | output | 20 | Physical address |
| refill_req_valid | output | 1 | Refill outstanding |
| refill_req_instr | output | 1 | Side of the outstanding refill |
| refill_req_vpn | output | 14 | Page number to refill |
| refill_rsp_valid | input | 1 | Refill response present |
| refill_rsp_ppn | input | 8 | Physical page number of the refill |
| i_access_cnt | output | 16 | Instruction-side access count |
| i_hit_cnt | output | 16 | Instruction-side hit count |
| d_access_cnt | output | 16 | Data-side access count |
| d_hit_cnt | output | 16 | Data-side hit count |

## Verification
Every result of this block is due exactly one clock edge after its cause:
- a hit response follows the acceptance edge;
- the refill request and the counter updates follow the acceptance edge;
- the refill response follows the edge that took the refill.

`req_ready` is the only output that reacts within the same cycle, and only to `flush`. The bench keeps a behavioural model that applies the same events at each rising edge. It compares every output 2 ns after the falling edge, so that registered results and the combinational ready have both settled before inputs change again.

// File: rtl/split_tlb_pkg.sv
package split_tlb_pkg;
  localparam int VA_W  = 26;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;

  typedef enum logic [0:0] {REPL_LRU, REPL_RAND} repl_e;

  localparam logic [31:0] LFSR_SEED = 32'd14897;
  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter logic [31:0] SEED = 32'd1,
  parameter logic [31:0] MASK = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [31:0] state
);
  logic [31:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step) state_d = state_q[0] ? ((state_q >> 1) ^ MASK) : (state_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/tlb_side.sv
module tlb_side import split_tlb_pkg::*; #(
  parameter int    SETS  = 4,
  parameter int    WAYS  = 4,
  parameter int    PPN_W = 8,
  parameter repl_e REPL  = REPL_LRU,
  localparam int   WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [WAY_W-1:0] rnd
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, f_tag;
  logic [WAY_W-1:0] lk_way, free_way, repl_way, victim;
  logic             free_any;

  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign f_idx  = fill_vpn[IDX_W-1:0];
  assign f_tag  = fill_vpn[VPN_W-1:IDX_W];

  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag)) begin
        lk_hit = 1'b1;
        lk_way = WAY_W'(w);
        lk_ppn = ppn_q[lk_idx][w];
      end
    end
  end

  // lowest invalid way wins over the replacement choice
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[f_idx][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    victim = free_any ? free_way : repl_way;
  end

  always_comb begin
    vld_d = vld_q;
    if (flush) begin
      for (int s = 0; s < SETS; s++) vld_d[s] = '0;
    end else if (fill_en) begin
      vld_d[f_idx][victim] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[f_idx][victim] <= f_tag;
      ppn_q[f_idx][victim] <= fill_ppn;
    end
  end

  generate
    if (REPL == REPL_LRU) begin : g_lru
      logic [WAY_W-1:0] age_q [SETS][WAYS];
      logic [WAY_W-1:0] age_d [SETS][WAYS];
      logic             touch;
      logic [IDX_W-1:0] t_idx;
      logic [WAY_W-1:0] t_way;
      logic             unused_rnd;

      assign unused_rnd = ^rnd;
      assign touch = fill_en || (lk_en && lk_hit);
      assign t_idx = fill_en ? f_idx  : lk_idx;
      assign t_way = fill_en ? victim : lk_way;

      always_comb begin
        age_d = age_q;
        if (flush) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) age_d[s][w] = WAY_W'(w);
        end else if (touch) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == t_way)
              age_d[t_idx][w] = '0;
            else if (age_q[t_idx][w] < age_q[t_idx][t_way])
              age_d[t_idx][w] = age_q[t_idx][w] + 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        end else begin
          age_q <= age_d;
        end
      end

      always_comb begin
        repl_way = '0;
        for (int w = 0; w < WAYS; w++)
          if (age_q[f_idx][w] == WAY_W'(WAYS - 1)) repl_way = WAY_W'(w);
      end
    end else begin : g_rand
      logic unused_lk;
      assign unused_lk = lk_en ^ (^lk_way);
      assign repl_way  = rnd;
    end
  endgenerate
endmodule

// File: rtl/split_tlb.sv
module split_tlb import split_tlb_pkg::*; #(
  parameter int I_ENTRIES = 16,
  parameter int D_ENTRIES = 32,
  parameter int WAYS      = 4,
  parameter int PPN_W     = 8,
  parameter int CNT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_instr,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   resp_valid,
  output logic                   resp_hit,
  output logic [PPN_W+OFF_W-1:0] resp_paddr,
  output logic                   refill_req_valid,
  output logic                   refill_req_instr,
  output logic [VPN_W-1:0]       refill_req_vpn,
  input  logic                   refill_rsp_valid,
  input  logic [PPN_W-1:0]       refill_rsp_ppn,
  output logic [CNT_W-1:0]       i_access_cnt,
  output logic [CNT_W-1:0]       i_hit_cnt,
  output logic [CNT_W-1:0]       d_access_cnt,
  output logic [CNT_W-1:0]       d_hit_cnt
);
  localparam int I_SETS = I_ENTRIES / WAYS;
  localparam int D_SETS = D_ENTRIES / WAYS;
  localparam int WAY_W  = $clog2(WAYS);

  logic             accept, take, lk_hit, unused_write;
  logic             i_hit, d_hit;
  logic [PPN_W-1:0] i_ppn, d_ppn, lk_ppn;
  logic [31:0]      lfsr;
  logic [VPN_W-1:0] req_vpn;

  logic             busy_q, busy_d, pinstr_q;
  logic [VPN_W-1:0] pvpn_q;
  logic [OFF_W-1:0] poff_q;
  logic             rv_q, rv_d, rh_q, rh_d;
  logic [PPN_W+OFF_W-1:0] pa_q, pa_d;
  logic [CNT_W-1:0] ia_q, ih_q, da_q, dh_q;

  assign unused_write = req_write;
  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign accept  = req_valid && !busy_q && !flush;
  assign take    = busy_q && refill_rsp_valid && !flush;
  assign lk_hit  = req_instr ? i_hit : d_hit;
  assign lk_ppn  = req_instr ? i_ppn : d_ppn;

  tlb_side #(.SETS(I_SETS), .WAYS(WAYS), .PPN_W(PPN_W), .REPL(REPL_LRU)) u_iside (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_en(accept && req_instr), .lk_vpn(req_vpn), .lk_hit(i_hit), .lk_ppn(i_ppn),
    .fill_en(take && pinstr_q), .fill_vpn(pvpn_q), .fill_ppn(refill_rsp_ppn),
    .rnd(lfsr[WAY_W-1:0])
  );

  tlb_side #(.SETS(D_SETS), .WAYS(WAYS), .PPN_W(PPN_W), .REPL(REPL_RAND)) u_dside (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_en(accept && !req_instr), .lk_vpn(req_vpn), .lk_hit(d_hit), .lk_ppn(d_ppn),
    .fill_en(take && !pinstr_q), .fill_vpn(pvpn_q), .fill_ppn(refill_rsp_ppn),
    .rnd(lfsr[WAY_W-1:0])
  );

  tlb_lfsr #(.SEED(LFSR_SEED), .MASK(LFSR_MASK)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(take && !pinstr_q), .state(lfsr)
  );

  always_comb begin
    busy_d = busy_q;
    if (flush || take)         busy_d = 1'b0;
    else if (accept && !lk_hit) busy_d = 1'b1;
    rv_d = !flush && ((accept && lk_hit) || take);
    rh_d = accept && lk_hit;
    pa_d = accept ? {lk_ppn, req_vaddr[OFF_W-1:0]} : {refill_rsp_ppn, poff_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pinstr_q <= 1'b0;
      pvpn_q   <= '0;
      poff_q   <= '0;
      rv_q     <= 1'b0;
      rh_q     <= 1'b0;
      pa_q     <= '0;
      ia_q     <= '0;
      ih_q     <= '0;
      da_q     <= '0;
      dh_q     <= '0;
    end else begin
      busy_q <= busy_d;
      rv_q   <= rv_d;
      if (accept) begin
        pinstr_q <= req_instr;
        pvpn_q   <= req_vpn;
        poff_q   <= req_vaddr[OFF_W-1:0];
      end
      if (rv_d) begin
        rh_q <= rh_d;
        pa_q <= pa_d;
      end
      if (accept &&  req_instr)           ia_q <= ia_q + 1'b1;
      if (accept &&  req_instr && lk_hit) ih_q <= ih_q + 1'b1;
      if (accept && !req_instr)           da_q <= da_q + 1'b1;
      if (accept && !req_instr && lk_hit) dh_q <= dh_q + 1'b1;
    end
  end

  assign req_ready        = !busy_q && !flush;
  assign resp_valid       = rv_q;
  assign resp_hit         = rh_q;
  assign resp_paddr       = pa_q;
  assign refill_req_valid = busy_q;
  assign refill_req_instr = pinstr_q;
  assign refill_req_vpn   = pvpn_q;
  assign i_access_cnt     = ia_q;
  assign i_hit_cnt        = ih_q;
  assign d_access_cnt     = da_q;
  assign d_hit_cnt        = dh_q;
endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_instr,
  input logic [11:0]      req_off,
  input logic             lk_hit,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [11:0]      resp_off,
  input logic             refill_req_valid,
  input logic             refill_rsp_valid,
  input logic [CNT_W-1:0] i_access_cnt,
  input logic [CNT_W-1:0] d_access_cnt
);
  a_r3_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_valid |-> !req_ready);

  a_r2_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit) |=> (resp_valid && resp_hit));

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit) |=> (resp_off == $past(req_off)));

  a_r3_miss_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !lk_hit) |=> (refill_req_valid && !resp_valid));

  a_r3_refill_done: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req_valid && refill_rsp_valid && !flush) |=>
      (resp_valid && !resp_hit && !refill_req_valid));

  a_r7_i_access: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_instr) |=> (i_access_cnt == $past(i_access_cnt) + 1'b1));

  a_r7_d_access: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_instr) |=> (d_access_cnt == $past(d_access_cnt) + 1'b1));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!refill_req_valid && !resp_valid));
endmodule

bind split_tlb split_tlb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .req_valid(req_valid), .req_ready(req_ready), .req_instr(req_instr),
  .req_off(req_vaddr[11:0]), .lk_hit(lk_hit),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_off(resp_paddr[11:0]),
  .refill_req_valid(refill_req_valid), .refill_rsp_valid(refill_rsp_valid),
  .i_access_cnt(i_access_cnt), .d_access_cnt(d_access_cnt)
);

// File: tb/split_tlb_test.sv
`timescale 1ns/1ps
module split_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_instr = 1'b0;
  logic [25:0] req_vaddr = '0;
  logic        req_ready, resp_valid, resp_hit;
  logic [19:0] resp_paddr;
  logic        refill_req_valid, refill_req_instr;
  logic [13:0] refill_req_vpn;
  logic        refill_rsp_valid;
  logic [7:0]  refill_rsp_ppn = '0;
  logic [15:0] i_access_cnt, i_hit_cnt, d_access_cnt, d_hit_cnt;

  logic rsp_drv = 1'b0, stray = 1'b0, hold = 1'b0;
  assign refill_rsp_valid = rsp_drv | stray;

  always #5 clk = ~clk;

  split_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_instr(req_instr), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
    .refill_req_valid(refill_req_valid), .refill_req_instr(refill_req_instr),
    .refill_req_vpn(refill_req_vpn),
    .refill_rsp_valid(refill_rsp_valid), .refill_rsp_ppn(refill_rsp_ppn),
    .i_access_cnt(i_access_cnt), .i_hit_cnt(i_hit_cnt),
    .d_access_cnt(d_access_cnt), .d_hit_cnt(d_hit_cnt)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string phase = "R9 reset";

  // ---------------- behavioural reference ----------------
  bit       iv [4][4];  int it [4][4]; int ip [4][4]; int iord [4][$];
  bit       dv [8][4];  int dt [8][4]; int dp [8][4];
  bit [31:0] m_lfsr;
  bit        m_busy, m_pi, m_rv, m_rh;
  int        m_pvpn, m_poff, m_pa;
  int        m_ia, m_ih, m_da, m_dh;

  function automatic void reset_order();
    for (int s = 0; s < 4; s++) begin
      iord[s].delete();
      for (int w = 0; w < 4; w++) iord[s].push_back(w);
    end
  endfunction

  function automatic void mru(int s, int w);
    for (int k = 0; k < iord[s].size(); k++)
      if (iord[s][k] == w) begin iord[s].delete(k); break; end
    iord[s].push_front(w);
  endfunction

  function automatic void install(bit ins, int vpn, int ppn);
    int s, w;
    w = -1;
    if (ins) begin
      s = vpn % 4;
      for (int k = 3; k >= 0; k--) if (!iv[s][k]) w = k;
      if (w < 0) w = iord[s][3];
      iv[s][w] = 1; it[s][w] = vpn / 4; ip[s][w] = ppn;
      mru(s, w);
    end else begin
      s = vpn % 8;
      for (int k = 3; k >= 0; k--) if (!dv[s][k]) w = k;
      if (w < 0) w = int'(m_lfsr[1:0]);
      dv[s][w] = 1; dt[s][w] = vpn / 8; dp[s][w] = ppn;
      m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 32'h8020_0003) : (m_lfsr >> 1);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (iv[s, w]) iv[s][w] = 0;
      foreach (dv[s, w]) dv[s][w] = 0;
      reset_order();
      m_lfsr = 32'd14897;
      m_busy = 0; m_rv = 0; m_rh = 0; m_pa = 0; m_pi = 0; m_pvpn = 0; m_poff = 0;
      m_ia = 0; m_ih = 0; m_da = 0; m_dh = 0;
    end else begin
      bit acc, tk, hit;
      int vpn, off, ppn, s;
      acc = req_valid && !m_busy && !flush;
      tk  = m_busy && refill_rsp_valid && !flush;
      vpn = int'(req_vaddr[25:12]);
      off = int'(req_vaddr[11:0]);
      if (flush) begin
        foreach (iv[a, b]) iv[a][b] = 0;
        foreach (dv[a, b]) dv[a][b] = 0;
        reset_order();
        m_busy = 0; m_rv = 0;
      end else if (tk) begin
        install(m_pi, m_pvpn, int'(refill_rsp_ppn));
        m_rv = 1; m_rh = 0; m_pa = int'(refill_rsp_ppn) * 4096 + m_poff; m_busy = 0;
      end else if (acc) begin
        hit = 0; ppn = 0;
        if (req_instr) begin
          s = vpn % 4;
          for (int w = 0; w < 4; w++)
            if (iv[s][w] && it[s][w] == vpn / 4) begin hit = 1; ppn = ip[s][w]; mru(s, w); end
          m_ia++; if (hit) m_ih++;
        end else begin
          s = vpn % 8;
          for (int w = 0; w < 4; w++)
            if (dv[s][w] && dt[s][w] == vpn / 8) begin hit = 1; ppn = dp[s][w]; end
          m_da++; if (hit) m_dh++;
        end
        if (hit) begin m_rv = 1; m_rh = 1; m_pa = ppn * 4096 + off; end
        else begin m_rv = 0; m_busy = 1; m_pi = req_instr; m_pvpn = vpn; m_poff = off; end
      end else begin
        m_rv = 0;
      end
      m_ia &= 16'hffff; m_ih &= 16'hffff; m_da &= 16'hffff; m_dh &= 16'hffff;
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL [%s] %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      cmp("R3 R8 req_ready", int'(req_ready), int'(!m_busy && !flush));
      cmp("R2 R3 resp_valid", int'(resp_valid), int'(m_rv));
      if (m_rv) begin
        cmp("R4 R5 R6 resp_hit", int'(resp_hit), int'(m_rh));
        cmp("R1 resp_paddr", int'(resp_paddr), m_pa);
      end
      cmp("R3 R10 refill_req_valid", int'(refill_req_valid), int'(m_busy));
      if (m_busy) begin
        cmp("R3 refill_req_vpn", int'(refill_req_vpn), m_pvpn);
        cmp("R3 refill_req_instr", int'(refill_req_instr), int'(m_pi));
      end
      cmp("R7 i_access_cnt", int'(i_access_cnt), m_ia);
      cmp("R7 i_hit_cnt", int'(i_hit_cnt), m_ih);
      cmp("R7 d_access_cnt", int'(d_access_cnt), m_da);
      cmp("R7 d_hit_cnt", int'(d_hit_cnt), m_dh);
    end
  end

  // refill responder
  int dly = 0;
  always @(negedge clk) begin
    if (rsp_drv) rsp_drv = 1'b0;
    else if (refill_req_valid && !hold) begin
      if (dly == 0) begin
        rsp_drv = 1'b1;
        refill_rsp_ppn = 8'((int'(refill_req_vpn) * 37 + 11));
        dly = $urandom_range(0, 3);
      end else dly--;
    end
  end

  task automatic issue(bit ins, int vpn, int off);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_instr = ins; req_write = $urandom_range(0, 1) == 1;
    req_vaddr = 26'(vpn * 4096 + off);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    phase = "R2 R4 instruction fills";
    for (int k = 0; k < 4; k++) issue(1, k * 4, 16 * k + 5);
    for (int k = 0; k < 4; k++) issue(1, k * 4, 100 + k);
    settle();

    phase = "R5 LRU eviction";
    issue(1, 0, 1); issue(1, 8, 2);
    issue(1, 16, 3); issue(1, 4, 4);
    issue(1, 12, 5); issue(1, 0, 6); issue(1, 16, 7);
    settle();

    phase = "R6 data random victims";
    for (int k = 0; k < 10; k++) issue(0, k * 8 + 3, k);
    for (int k = 0; k < 10; k++) issue(0, k * 8 + 3, 4095 - k);
    settle();

    phase = "R1 offsets";
    issue(0, 3, 12'hfff); issue(0, 3, 0); issue(1, 12, 12'h800); issue(0, 16383, 7);
    settle();

    phase = "R10 stray refill";
    @(negedge clk); stray = 1'b1; refill_rsp_ppn = 8'hAA;
    @(negedge clk); stray = 1'b0;
    issue(1, 12, 9);
    settle();

    phase = "R8 flush";
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    issue(1, 12, 1); issue(0, 3, 2);
    settle();
    hold = 1'b1;
    issue(0, 999, 3);
    repeat (3) @(negedge clk);
    flush = 1'b1;
    @(negedge clk); flush = 1'b0; hold = 1'b0;
    issue(0, 999, 4); issue(0, 999, 5);
    settle();

    phase = "R7 mixed traffic";
    for (int k = 0; k < 400; k++)
      issue($urandom_range(0, 1) == 1, $urandom_range(0, 47), $urandom_range(0, 4095));
    settle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule